// File: doc/BRIEF.md
# Outer-Banked Program and Character Bank Mapper

This block translates processor and picture-unit fetch addresses for a cartridge that holds a large multi-game ROM. It has a command/data register pair in the classic style, with six character-slot registers and two program-slot registers. A set of outer-bank registers lets software cut the ROM into smaller images at run time. Every 8 KB program bank is assembled from three parts: an outer base, a switchable inner part kept under a programmable mask, and a fixed part that fills the bits outside that mask. Every 1 KB character bank is offset by a base that is built from three registers.

Register writes arrive as an address, a data byte and a one-cycle strobe. They are captured on the following rising clock edge. The bank numbers and the nametable arrangement bit are purely combinational functions of the stored registers and the current lookup address. Writes to the scanline-interrupt addresses are decoded and then dropped, because that unit lives elsewhere.

Top module: `obmap_mapper`

## Requirements
- R1: After reset all sixteen general registers and six character registers read zero, except general register 9 = 0x3E and register 10 = 0x3F. So windows 0x8000/0xA000/0xC000/0xE000 give banks 0x000/0x000/0x03E/0x03F, character slots 0..7 give 0,1,0,1,0,0,0,0, and the arrangement bit is 0.
- R2: A write whose address ANDed with 0xE001 equals 0x8000 loads the command register (general register 15); bits [2:0] select the target, bit 6 and bit 7 are swap controls. 0x8001 (same decode) is the data port, so aliases such as 0x9FFE/0x9FFF act identically.
- R3: With program mask PM = 0x3F >> reg11[3:0] and outer base reg0[7:4] placed at bank bits [11:8], the windows at 0x8000 and 0xA000 give base | (reg7 or reg8 AND PM) | (reg10 AND NOT PM).
- R4: With mode register bit 1 set, the 0xC000 window gives base | (reg9 AND PM) | (reg10 AND NOT PM), and the 0xE000 window gives base | reg10.
- R5: With mode register bit 1 clear, the 0xC000 window gives base | (0xFE AND PM) | (reg10 AND NOT PM), and the 0xE000 window gives base | (0xFF AND PM) | (reg10 AND NOT PM).
- R6: When mode bit 0 and command bit 6 are both set, the 0x8000 and 0xC000 windows exchange their bank values; 0xA000 and 0xE000 are unaffected.
- R7: The character base is ((reg0[3:0]<<8) | (reg12<<1) | (mode>>3)) << 3, ORed into every slot. Slots 0..7 take c0&0xFE, c0|1, c1, c1|1, c2, c3, c4, c5. Command bit 7 exchanges slots 0..3 with 4..7.
- R8: Data for targets 0..5 is stored ANDed with 0x0F when mode bit 2 is set, otherwise ANDed with 0xFF >> reg11[7:4].
- R9: Data for targets 6 and 7 replaces only the bits of reg7 or reg8 selected by PM and keeps the rest.
- R10: A write to 0xA000 (decoded) sets the arrangement output to the inverse of data bit 0.
- R11: Writes decoding to 0xC000, 0xC001, 0xE000 or 0xE001 change no register and no output.
- R12: Address 0x2018 loads reg12, 0x201A loads the mode register (reg13), and 0x4100..0x410F load general register addr[3:0] directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | Program fetch address (bits 14:13 pick the window) |
| ppu_addr | input | 14 | Character fetch address (bits 12:10 pick the slot) |
| prg_bank | output | 12 | 8 KB program bank number |
| chr_bank | output | 15 | 1 KB character bank number |
| mirror_sel | output | 1 | Nametable arrangement bit |

## Verification
The assertions check on every cycle that the outer base always appears in the program bank's top bits. They also check that aliased command writes land in the command register, that masked character data never keeps high bits in nibble mode, that the arrangement bit follows the last decoded write, that interrupt-unit writes leave all state unchanged, and that reset leaves the fixed registers at their preset values. Only the bench's sweeps can show the full bank arithmetic. These sweeps cover each mask width, each mode-bit combination, both swap controls and partial program updates, and they compare every window and slot against values computed from the requirements.

// File: rtl/obmap_pkg.sv
package obmap_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int NREG   = 16;
  localparam int NCHR   = 6;
  localparam int NWIN   = 4;
  localparam int NSLOT  = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int PRG_W  = DW + DW / 2;
  localparam int CHR_W  = DW + DW / 2 + 3;

  typedef logic [NREG-1:0][DW-1:0] regs_t;
  typedef logic [NCHR-1:0][DW-1:0] chrr_t;

  localparam logic [RIDX_W-1:0] R_OUTER = 4'd0;
  localparam logic [RIDX_W-1:0] R_P0    = 4'd7;
  localparam logic [RIDX_W-1:0] R_P1    = 4'd8;
  localparam logic [RIDX_W-1:0] R_P2    = 4'd9;
  localparam logic [RIDX_W-1:0] R_FIX   = 4'd10;
  localparam logic [RIDX_W-1:0] R_MASK  = 4'd11;
  localparam logic [RIDX_W-1:0] R_CMID  = 4'd12;
  localparam logic [RIDX_W-1:0] R_MODE  = 4'd13;
  localparam logic [RIDX_W-1:0] R_MIR   = 4'd14;
  localparam logic [RIDX_W-1:0] R_CMD   = 4'd15;
endpackage

// File: rtl/obmap_regs.sv
module obmap_regs
  import obmap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output regs_t         gr,
  output chrr_t         cr
);
  logic [2:0]        cmd;
  logic [DW-1:0]     cmask;
  logic [DW-1:0]     pmask;
  logic [RIDX_W-1:0] pidx;
  logic [AW-1:0]     mdec;

  assign cmd   = gr[R_CMD][2:0];
  assign cmask = gr[R_MODE][2] ? 8'h0F : (8'hFF >> gr[R_MASK][7:4]);
  assign pmask = 8'h3F >> gr[R_MASK][3:0];
  assign pidx  = {1'b0, cmd} + 4'd1;
  assign mdec  = wr_addr & 16'hE001;

  always_ff @(posedge clk) begin
    if (rst) begin
      gr        <= '0;
      gr[R_P2]  <= 8'h3E;
      gr[R_FIX] <= 8'h3F;
      cr        <= '0;
    end else if (wr_en) begin
      if (wr_addr[AW-1:4] == 12'h410) begin
        gr[wr_addr[3:0]] <= wr_data;
      end else if (wr_addr == 16'h2018) begin
        gr[R_CMID] <= wr_data;
      end else if (wr_addr == 16'h201A) begin
        gr[R_MODE] <= wr_data;
      end else if (wr_addr[AW-1]) begin
        case (mdec)
          16'h8000: gr[R_CMD] <= wr_data;
          16'h8001: begin
            if (cmd < 3'd6) cr[cmd] <= wr_data & cmask;
            else            gr[pidx] <= (gr[pidx] & ~pmask) | (wr_data & pmask);
          end
          16'hA000: gr[R_MIR] <= {{(DW-1){1'b0}}, ~wr_data[0]};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/obmap_prg.sv
module obmap_prg
  import obmap_pkg::*;
(
  input  regs_t            gr,
  input  logic [1:0]       win,
  output logic [PRG_W-1:0] bank
);
  logic [DW-1:0]    pm;
  logic [DW-1:0]    fill;
  logic [PRG_W-1:0] base;
  logic             swap;
  logic [1:0]       eff;
  logic [NWIN-1:0][PRG_W-1:0] wb;

  assign pm   = 8'h3F >> gr[R_MASK][3:0];
  assign fill = gr[R_FIX] & ~pm;
  assign base = {gr[R_OUTER][7:4], {DW{1'b0}}};
  assign swap = gr[R_MODE][0] & gr[R_CMD][6];
  assign eff  = win ^ {swap & ~win[0], 1'b0};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [DW-1:0] inner;
    if (w == 0) begin : g_a
      assign inner = gr[R_P0];
      assign wb[w] = base | {4'h0, (inner & pm) | fill};
    end else if (w == 1) begin : g_b
      assign inner = gr[R_P1];
      assign wb[w] = base | {4'h0, (inner & pm) | fill};
    end else if (w == 2) begin : g_c
      assign inner = gr[R_MODE][1] ? gr[R_P2] : 8'hFE;
      assign wb[w] = base | {4'h0, (inner & pm) | fill};
    end else begin : g_d
      assign inner = 8'hFF;
      assign wb[w] = gr[R_MODE][1] ? (base | {4'h0, gr[R_FIX]})
                                   : (base | {4'h0, (inner & pm) | fill});
    end
  end

  assign bank = wb[eff];
endmodule

// File: rtl/obmap_chr.sv
module obmap_chr
  import obmap_pkg::*;
(
  input  regs_t            gr,
  input  chrr_t            cr,
  input  logic [2:0]       slot,
  output logic [CHR_W-1:0] bank
);
  logic [CHR_W-4:0] mid;
  logic [CHR_W-1:0] cbase;
  logic [2:0]       eff;
  logic [NSLOT-1:0][DW-1:0] sv;

  assign mid   = {gr[R_OUTER][3:0], {DW{1'b0}}}
               | {3'b000, gr[R_CMID], 1'b0}
               | {7'b0, gr[R_MODE][7:3]};
  assign cbase = {mid, 3'b000};
  assign eff   = slot ^ {gr[R_CMD][7], 2'b00};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == 0) begin : g_s0
      assign sv[s] = cr[0] & 8'hFE;
    end else if (s == 1) begin : g_s1
      assign sv[s] = cr[0] | 8'h01;
    end else if (s == 2) begin : g_s2
      assign sv[s] = cr[1];
    end else if (s == 3) begin : g_s3
      assign sv[s] = cr[1] | 8'h01;
    end else begin : g_sx
      assign sv[s] = cr[s-2];
    end
  end

  assign bank = cbase | {{(CHR_W-DW){1'b0}}, sv[eff]};
endmodule

// File: rtl/obmap_mapper.sv
module obmap_mapper
  import obmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [13:0]       ppu_addr,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              mirror_sel
);
  regs_t gr;
  chrr_t cr;

  obmap_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gr(gr), .cr(cr)
  );

  obmap_prg u_prg (.gr(gr), .win(cpu_addr[14:13]), .bank(prg_bank));

  obmap_chr u_chr (.gr(gr), .cr(cr), .slot(ppu_addr[12:10]), .bank(chr_bank));

  assign mirror_sel = gr[R_MIR][0];
endmodule

// File: rtl/obmap_chk.sv
module obmap_chk
  import obmap_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input regs_t            gr,
  input chrr_t            cr,
  input logic [PRG_W-1:0] prg_bank,
  input logic             mirror_sel
);
  logic mwr;
  logic [AW-1:0] dec;
  assign mwr = wr_en && wr_addr[AW-1];
  assign dec = wr_addr & 16'hE001;

  p_reset_fixed_r1: assert property (@(posedge clk)
    $fell(rst) |-> (gr[R_P2] == 8'h3E && gr[R_FIX] == 8'h3F && gr[R_CMD] == 8'h00));

  p_cmd_alias_r2: assert property (@(posedge clk) disable iff (rst)
    (mwr && dec == 16'h8000) |=> gr[R_CMD] == $past(wr_data));

  p_outer_base_r3: assert property (@(posedge clk) disable iff (rst)
    prg_bank[PRG_W-1:DW] == gr[R_OUTER][7:4]);

  p_nibble_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (mwr && dec == 16'h8001 && gr[R_CMD][2:0] < 3'd6 && gr[R_MODE][2])
    |=> cr[$past(gr[R_CMD][2:0])][7:4] == 4'h0);

  p_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    (mwr && dec == 16'hA000) |=> mirror_sel == ~$past(wr_data[0]));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (mwr && (dec == 16'hC000 || dec == 16'hC001 || dec == 16'hE000 || dec == 16'hE001))
    |=> ($stable(gr) && $stable(cr)));
endmodule

bind obmap_mapper obmap_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .gr(gr), .cr(cr), .prg_bank(prg_bank), .mirror_sel(mirror_sel)
);

// File: tb/sim_obmap_mapper.sv
module sim_obmap_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [13:0] ppu_addr = '0;
  logic [11:0] prg_bank;
  logic [14:0] chr_bank;
  logic        mirror_sel;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  logic [7:0] m [16];
  logic [7:0] mc [6];

  always #4 clk = ~clk;

  obmap_mapper u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .mirror_sel(mirror_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    for (int i = 0; i < 6; i++) mc[i] = 8'h00;
    m[9] = 8'h3E; m[10] = 8'h3F;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] dec;
    logic [7:0]  pm, cm;
    int c;
    dec = a & 16'hE001;
    pm  = 8'h3F >> m[11][3:0];
    cm  = m[13][2] ? 8'h0F : (8'hFF >> m[11][7:4]);
    c   = m[15][2:0];
    if (a[15:4] == 12'h410) m[a[3:0]] = d;
    else if (a == 16'h2018) m[12] = d;
    else if (a == 16'h201A) m[13] = d;
    else if (a[15]) begin
      if (dec == 16'h8000) m[15] = d;
      else if (dec == 16'h8001) begin
        if (c < 6) mc[c] = d & cm;
        else m[c+1] = (m[c+1] & ~pm) | (d & pm);
      end else if (dec == 16'hA000) m[14] = {7'b0, ~d[0]};
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  function automatic int exp_prg(input int w);
    logic [7:0] pm, v;
    int base, e;
    logic sw;
    sw = m[13][0] & m[15][6];
    e  = ((w == 0 || w == 2) && sw) ? (w ^ 2) : w;
    pm = 8'h3F >> m[11][3:0];
    base = int'(m[0][7:4]) * 256;
    if (e == 0) v = m[7];
    else if (e == 1) v = m[8];
    else if (e == 2) v = m[13][1] ? m[9] : 8'hFE;
    else v = 8'hFF;
    if (e == 3 && m[13][1]) return base | int'(m[10]);
    return base | int'((v & pm) | (m[10] & ~pm));
  endfunction

  function automatic int exp_chr(input int s);
    int e, base;
    logic [7:0] v;
    e = s ^ (m[15][7] ? 4 : 0);
    case (e)
      0: v = mc[0] & 8'hFE;
      1: v = mc[0] | 8'h01;
      2: v = mc[1];
      3: v = mc[1] | 8'h01;
      default: v = mc[e-2];
    endcase
    base = ((int'(m[0][3:0]) * 256) | (int'(m[12]) * 2) | int'(m[13] >> 3)) * 8;
    return base | int'(v);
  endfunction

  task automatic check_all(input string ctx);
    for (int w = 0; w < 4; w++) begin
      string tag;
      cpu_addr = 16'h8000 | 16'(w << 13) | 16'h0123;
      #1;
      if (m[13][0] && m[15][6] && (w == 0 || w == 2)) tag = "R6";
      else if (w < 2) tag = "R3/R9";
      else tag = m[13][1] ? "R4" : "R5";
      check({tag, " prg ", ctx}, int'(prg_bank), exp_prg(w));
    end
    for (int s = 0; s < 8; s++) begin
      ppu_addr = 14'(s << 10) | 14'h02A;
      #1;
      check({"R7/R8 chr ", ctx}, int'(chr_bank), exp_chr(s));
    end
    check({"R10 mirror ", ctx}, int'(mirror_sel), int'(m[14][0]));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, checked against literal values
    for (int w = 0; w < 4; w++) begin
      cpu_addr = 16'h8000 | 16'(w << 13);
      #1;
      check("R1 reset prg", int'(prg_bank), (w == 2) ? 32'h3E : ((w == 3) ? 32'h3F : 0));
    end
    for (int s = 0; s < 8; s++) begin
      ppu_addr = 14'(s << 10);
      #1;
      check("R1 reset chr", int'(chr_bank), (s == 1 || s == 3) ? 1 : 0);
    end
    check("R1 reset mirror", int'(mirror_sel), 0);

    // R2 aliased command/data addresses
    wr(16'h9FFE, 8'h06);
    wr(16'h9FFF, 8'h15);
    cpu_addr = 16'h8000; #1;
    check("R2 alias data to reg7", int'(prg_bank), 32'h15);

    // R12 direct loads and R10 arrangement
    wr(16'h2018, 8'h5C);
    wr(16'h201A, 8'h08);
    wr(16'h4100, 8'h31);
    wr(16'hA000, 8'h00);
    check_all("R12 loads");
    wr(16'hBFFE, 8'h01);
    check_all("R10 alias A000");

    // R11 interrupt-unit writes ignored
    wr(16'hC000, 8'hFF);
    wr(16'hC001, 8'hFF);
    wr(16'hE000, 8'hFF);
    wr(16'hFFFF, 8'hFF);
    check_all("R11 irq writes");

    // sweep: modes, mask widths, commands with swap bits
    for (int md = 0; md < 8; md++) begin
      for (int bk = 0; bk < 8; bk++) begin
        wr(16'h410B, 8'((bk << 4) | bk));
        wr(16'h201A, 8'((md * 8'h29) & 8'hF8) | 8'(md));
        wr(16'h2018, 8'(bk * 29 + md));
        wr(16'h4100, 8'(8'h5A ^ (md * 17) ^ bk));
        wr(16'h410A, 8'(8'h3F ^ (bk * 8'h45)));
        wr(16'h4109, 8'(8'h21 + md * 3));
        for (int c = 0; c < 8; c++) begin
          wr(16'h8000, 8'(c | ((c + md + bk) % 4) << 6));
          wr(16'h8001, 8'(8'hA7 ^ (c * 37) ^ (bk * 11)));
        end
        check_all("sweep");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule